// File: doc/BRIEF.md
# Windowed Watchdog Monitor

This block watches how often software services it, measuring time against a free-running reference timer. The timer supplies two pulses: one for each count it makes and one each time it overflows. Software services the watchdog by pulsing a write strobe. The block trips in two cases. One is a service that comes too late, meaning the reference timer has overflowed a set number of times with no write in between. The other is a service that comes too early, meaning two writes are separated by fewer than a set number of reference counts. Both cases are taken as signs of a runaway program.

A third cause of a trip is an illegal-address indication from an external decoder. It is acted on only while the chip runs in single-chip mode. Once the block trips, it holds an active-low fault level and asserts an output enable, so that a pad can pull an open-drain line low. The line can be wired to a reset or non-maskable interrupt input. The fault stays latched until the next system reset.

Top module: `wdogWindow`

## Requirements
- R1: Overflow pulses are counted from reset or from the last service. The overflow pulse that brings the count to MAX_OVF (default 2) with no service in the same cycle trips the watchdog. The trip shows at the outputs on the following clock edge.
- R2: A service write is early if fewer than MIN_TICKS (default 4096) count pulses have arrived since the previous service. An early write trips the watchdog on the following edge. A write after exactly MIN_TICKS count pulses is accepted.
- R3: An illegal-address pulse trips the watchdog on the following edge if singleChip is 1 in that cycle. If singleChip is 0, the illegal-address pulse has no effect.
- R4: Out of reset, woN is 1 and woOe is 0. When tripped, woN is 0 and woOe is 1.
- R5: A trip is held until rstN is asserted, whatever the inputs do afterwards.
- R6: A service write clears both the overflow count and the count-pulse count. Overflow or count pulses that arrive in the same cycle as the write are not counted.
- R7: The first service write after reset is never judged early.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| refTick | input | 1 | One-cycle pulse for each reference timer count |
| refOvf | input | 1 | One-cycle pulse for each reference timer overflow |
| svcWr | input | 1 | One-cycle software service write strobe |
| illegalAddr | input | 1 | Illegal access pulse from the address decoder |
| singleChip | input | 1 | 1 while the chip runs in single-chip mode |
| woN | output | 1 | Active-low watchdog fault level |
| woOe | output | 1 | Pad drive enable, 1 while tripped |

## Verification
The bench targets the edges of the minimum window:
- A write after MIN_TICKS-1 count pulses must trip. A write after MIN_TICKS pulses must not. A design that is off by one misses the first case or falsely trips on the second.
- A count pulse that lands in the same cycle as a write must not be counted. A design that counts it lets an early write through.

On the late side, the bench places an overflow in the same cycle as a write. A design that counts that overflow trips one overflow too soon. The bench also checks that the first write after reset is not judged early, and that illegal accesses are ignored outside single-chip mode. Long random runs check that the fault stays latched once set.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef struct packed {
    logic clrAll;   // service write: restart both windows
    logic incOvf;   // count one reference overflow
    logic incTick;  // count one reference tick
  } wdogStrobes_t;
endpackage

// File: rtl/wdogDatapath.sv
module wdogDatapath
  import wdog_pkg::*;
#(
  parameter int MAX_OVF   = 2,
  parameter int MIN_TICKS = 4096
) (
  input  logic         clk,
  input  logic         rstN,
  input  wdogStrobes_t stb,
  output logic         ovfLast,
  output logic         minMet
);
  localparam int OVF_W  = (MAX_OVF > 1) ? $clog2(MAX_OVF) : 1;
  localparam int TICK_W = $clog2(MIN_TICKS + 1);
  localparam logic [OVF_W-1:0]  OVF_TOP  = OVF_W'(MAX_OVF - 1);
  localparam logic [TICK_W-1:0] TICK_TOP = TICK_W'(MIN_TICKS);

  logic [OVF_W-1:0]  ovfCnt;
  logic [TICK_W-1:0] tickCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ovfCnt <= '0;
    end else if (stb.clrAll) begin
      ovfCnt <= '0;
    end else if (stb.incOvf && ovfCnt != OVF_TOP) begin
      ovfCnt <= ovfCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tickCnt <= '0;
    end else if (stb.clrAll) begin
      tickCnt <= '0;
    end else if (stb.incTick && tickCnt != TICK_TOP) begin
      tickCnt <= tickCnt + 1'b1;
    end
  end

  assign ovfLast = (ovfCnt == OVF_TOP);
  assign minMet  = (tickCnt == TICK_TOP);

  // R6: a service leaves both windows empty
  p_svc_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.clrAll |=> (ovfCnt == '0 && tickCnt == '0));
  p_tick_bounded_r2: assert property (@(posedge clk) disable iff (!rstN)
    tickCnt <= TICK_TOP);
endmodule

// File: rtl/wdogControl.sv
module wdogControl
  import wdog_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         refTick,
  input  logic         refOvf,
  input  logic         svcWr,
  input  logic         illegalAddr,
  input  logic         singleChip,
  input  logic         ovfLast,
  input  logic         minMet,
  output wdogStrobes_t stb,
  output logic         tripped
);
  logic armed;
  logic lateFault, earlyFault, addrFault;

  always_comb begin
    stb.clrAll  = svcWr;
    stb.incOvf  = refOvf && !svcWr;
    stb.incTick = refTick && !svcWr;
  end

  assign lateFault  = refOvf && !svcWr && ovfLast;
  assign earlyFault = svcWr && armed && !minMet;
  assign addrFault  = illegalAddr && singleChip;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      tripped <= 1'b0;
    end else begin
      if (svcWr) armed <= 1'b1;
      if (lateFault || earlyFault || addrFault) tripped <= 1'b1;
    end
  end

  p_late_trip_r1: assert property (@(posedge clk) disable iff (!rstN)
    (refOvf && !svcWr && ovfLast) |=> tripped);
  p_early_trip_r2: assert property (@(posedge clk) disable iff (!rstN)
    (svcWr && armed && !minMet) |=> tripped);
  p_addr_trip_r3: assert property (@(posedge clk) disable iff (!rstN)
    (illegalAddr && singleChip) |=> tripped);
  p_sticky_r5: assert property (@(posedge clk) disable iff (!rstN)
    tripped |=> tripped);
  p_first_free_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!armed && !tripped && svcWr && !refOvf && !(illegalAddr && singleChip)) |=> !tripped);
endmodule

// File: rtl/wdogWindow.sv
module wdogWindow
  import wdog_pkg::*;
#(
  parameter int MAX_OVF   = 2,
  parameter int MIN_TICKS = 4096
) (
  input  logic clk,
  input  logic rstN,
  input  logic refTick,
  input  logic refOvf,
  input  logic svcWr,
  input  logic illegalAddr,
  input  logic singleChip,
  output logic woN,
  output logic woOe
);
  wdogStrobes_t stb;
  logic ovfLast, minMet, tripped;

  wdogControl u_ctl (
    .clk(clk), .rstN(rstN), .refTick(refTick), .refOvf(refOvf),
    .svcWr(svcWr), .illegalAddr(illegalAddr), .singleChip(singleChip),
    .ovfLast(ovfLast), .minMet(minMet), .stb(stb), .tripped(tripped)
  );

  wdogDatapath #(.MAX_OVF(MAX_OVF), .MIN_TICKS(MIN_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .ovfLast(ovfLast), .minMet(minMet)
  );

  assign woN  = !tripped;
  assign woOe = tripped;

  p_pin_pair_r4: assert property (@(posedge clk) disable iff (!rstN)
    woOe != woN);
endmodule

// File: tb/sim_wdogWindow.sv
module sim_wdogWindow;
  localparam int PERIOD = 10;
  localparam int MAXO = 2;
  localparam int MINT = 4096;

  logic clk = 0, rstN = 0;
  logic refTick = 0, refOvf = 0, svcWr = 0, illegalAddr = 0, singleChip = 0;
  logic woN, woOe;
  int checks = 0, errors = 0;
  bit finished = 0;

  // reference model state
  int mOvf, mTicks;
  bit mArmed, mTrip;

  wdogWindow #(.MAX_OVF(MAXO), .MIN_TICKS(MINT)) u0 (
    .clk(clk), .rstN(rstN), .refTick(refTick), .refOvf(refOvf), .svcWr(svcWr),
    .illegalAddr(illegalAddr), .singleChip(singleChip), .woN(woN), .woOe(woOe));

  always #(PERIOD/2) clk = !clk;

  function automatic bit faultNow(bit t, bit o, bit s, bit i, bit c);
    return (i && c) || (o && !s && mOvf == MAXO-1) || (s && mArmed && mTicks < MINT);
  endfunction

  task automatic check(string req, bit expTrip);
    checks++;
    if (woN !== !expTrip || woOe !== expTrip) begin
      errors++;
      $display("FAIL %s woN=%b woOe=%b expected woN=%b woOe=%b", req, woN, woOe, !expTrip, expTrip);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    {refTick, refOvf, svcWr, illegalAddr, singleChip} = '0;
    rstN = 0;
    @(negedge clk);
    rstN = 1;
    mOvf = 0; mTicks = 0; mArmed = 0; mTrip = 0;
  endtask

  task automatic step(bit t, bit o, bit s, bit i, bit c);
    @(negedge clk);
    refTick = t; refOvf = o; svcWr = s; illegalAddr = i; singleChip = c;
    @(posedge clk);
    #1;
    if (faultNow(t, o, s, i, c)) mTrip = 1;
    if (s) begin mOvf = 0; mTicks = 0; mArmed = 1; end
    else begin
      if (o && mOvf < MAXO-1) mOvf++;
      if (t && mTicks < MINT) mTicks++;
    end
  endtask

  task automatic ticks(int n);
    for (int k = 0; k < n; k++) step(1, 0, 0, 0, 0);
  endtask

  initial begin
    #(PERIOD*200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    doReset();
    #1 check("R4 reset state", 0);

    // R7: first service after reset is free even with no ticks
    step(0, 0, 1, 0, 0); check("R7 first service", 0);
    // R2: early write at MINT-1 ticks
    ticks(MINT-1); step(0, 0, 1, 0, 0); check("R2 early write", 1);
    step(0, 0, 0, 0, 0); check("R5 sticky after early", 1);
    step(0, 0, 1, 0, 0); check("R5 sticky after service", 1);

    // R2: exactly MINT ticks accepted
    doReset(); step(0, 0, 1, 0, 0);
    ticks(MINT); step(0, 0, 1, 0, 0); check("R2 write at MINT ticks", 0);
    // R6: tick in service cycle ignored
    ticks(MINT-1); step(1, 0, 1, 0, 0); check("R6 tick in service cycle", 1);

    // R1: second overflow trips
    doReset();
    step(0, 1, 0, 0, 0); check("R1 first overflow", 0);
    step(0, 1, 0, 0, 0); #0 check("R1 second overflow", 1);

    // R6: overflow in service cycle not counted; service clears count
    doReset();
    step(0, 1, 0, 0, 0);
    step(0, 1, 1, 0, 0); check("R6 overflow with service", 0);
    step(0, 1, 0, 0, 0); check("R6 one overflow after service", 0);
    ticks(MINT); step(0, 0, 1, 0, 0); check("R6 service clears overflows", 0);
    step(0, 1, 0, 0, 0); check("R6 count restarted", 0);

    // R3
    doReset();
    step(0, 0, 0, 1, 0); check("R3 illegal ignored outside single-chip", 0);
    step(0, 0, 0, 0, 1); check("R3 mode alone", 0);
    step(0, 0, 0, 1, 1); check("R3 illegal in single-chip", 1);
    step(0, 0, 0, 0, 0); check("R4 tripped pin pair", 1);
    doReset(); #1 check("R5 reset clears trip", 0);

    // random segments
    void'($urandom(32'h5eed_1234));
    for (int seg = 0; seg < 16; seg++) begin
      doReset();
      for (int cyc = 0; cyc < 4000; cyc++) begin
        step(($urandom % 4) != 0, ($urandom % 2500) == 0, ($urandom % 3000) == 0,
             ($urandom % 6000) == 0, ($urandom % 2) == 0);
        check("R1/R2/R3/R5 random", mTrip);
      end
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule